// File: doc/BRIEF.md
# Multi-Mode Timer with Toggle Outputs

A 16-bit timer/counter whose single count register is shared by three compare channels. Each channel owns an output pin that inverts in hardware every time the counter reaches the channel's compare value. A steady square wave on any pin therefore runs without software help once the block is set up. Channel 0's compare value also sets the period in up mode and up/down mode.

The counter has four modes: halted, up (0 to the period value, then back to 0), continuous (the full 16-bit range) and up/down (up to the period value, then down to 0). It advances only on clock cycles in which the selected clock-enable input is high. A select bit chooses between two such enables. A small synchronous register port writes the mode, the enable select and the compare values, and issues a clear. Through the same port software reads the sticky event flags and the count. The flags are cleared by writing 1 to them.

In up mode, a period value of N-1 gives a pin that toggles every N timer ticks. In up/down mode, a period value of P gives one toggle every 2P ticks. This is because the compare event only fires on the way up.

Top module: `mm_timer`

## Requirements
- R1: After a synchronous reset the count, the direction, every output pin, every flag, every compare value and the control word are 0. Control value 0 means the halted mode.
- R2: Control bit 2 picks the count enable: 0 selects `tick_a` and 1 selects `tick_b`. The counter changes only on cycles where the selected enable is high.
- R3: Up mode is control bits [1:0] = 1. On each tick the count goes up by one. A tick at a count at or above the channel-0 value moves it to 0 instead and sets flag bit 0 (overflow). With the channel-0 value at N-1, pin 0 toggles every N ticks.
- R4: Continuous mode is control bits [1:0] = 2. The count goes up by one on each tick and wraps from 0xFFFF to 0, and that wrap sets flag bit 0.
- R5: Up/down mode is control bits [1:0] = 3, with P as the channel-0 value. The count runs 0,1,…,P,P-1,…,1,0,1,… and does not repeat P or 0, so one full cycle takes 2P ticks. Pin 0 toggles once every 2P ticks.
- R6: In up/down mode a channel's compare event fires only when the count moves upward from value-1 to its value. Moving down through the value has no effect. Overflow (flag bit 0) is set on the 1 to 0 step.
- R7: In up and continuous modes channel x (x = 0..2) inverts pin x and sets flag bit 1+x when the count moves onto its compare value. A compare value the count never reaches leaves the pin and the flag untouched.
- R8: In the halted mode (control bits [1:0] = 0) the count holds its value and no pin or flag changes.
- R9: A control write with bit 3 set clears the count, the direction and all pins at that edge, and a tick in the same cycle is ignored. Bit 3 is not stored and reads as 0.
- R10: Flags are sticky. Writing 1 to a bit at the flag address clears it. An event in the same cycle as its clear leaves the flag set.
- R11: The register addresses are: 0 control, 1 to 3 compare values for channels 0 to 2, 4 flags, 5 count (read only). `reg_rdata` shows the addressed register as it stood before the edge, one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Count enable source 0 |
| tick_b | input | 1 | Count enable source 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| cmp_out | output | 3 | Toggle outputs, one for each channel |

## Verification
Up mode is run with a steady enable and a short period. Channel 1 sits inside the period and channel 2 outside it, so the measured toggle gaps show the period arithmetic and the unreachable-compare case apart. Up/down mode is run with a compare value below the turnaround. Its 2P gap tells an upward-only compare event apart from one that fires in both directions. One long continuous run reaches the 16-bit wrap. A final phase drives random enables on both sources and random writes of modes, small compare values, clears and flag clears. In every phase, every cycle is compared against a behavioural model, which catches errors in turnaround, clear priority and the rule that a set beats a clear.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } mode_e;

  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_CLR_BIT  = 3;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_CMP_BASE = 1;

endpackage

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [CNT_W-1:0]               wdata,
  input  logic [CNT_W-1:0]               cnt,
  input  logic [NUM_CH-1:0]              cmp_evt,
  input  logic                           ovf_evt,
  output mode_e                          mode,
  output logic                           src_sel,
  output logic                           clr_pulse,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_val,
  output logic [NUM_CH:0]                flags,
  output logic [CNT_W-1:0]               rdata
);

  localparam int ADDR_FLAGS = ADDR_CMP_BASE + NUM_CH;
  localparam int ADDR_COUNT = ADDR_FLAGS + 1;

  logic             hit_ctrl;
  logic             hit_flags;
  logic [NUM_CH:0]  w1c_mask;
  logic [CNT_W-1:0] rd_mux;

  assign hit_ctrl  = we && (addr == ADDR_W'(ADDR_CTRL));
  assign hit_flags = we && (addr == ADDR_W'(ADDR_FLAGS));
  assign clr_pulse = hit_ctrl && wdata[CTRL_CLR_BIT];
  assign w1c_mask  = hit_flags ? wdata[NUM_CH:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_STOP;
      src_sel <= 1'b0;
    end else if (hit_ctrl) begin
      mode    <= mode_e'(wdata[1:0]);
      src_sel <= wdata[CTRL_SRC_BIT];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp_reg
    always_ff @(posedge clk) begin
      if (rst)
        cmp_val[g] <= '0;
      else if (we && (addr == ADDR_W'(ADDR_CMP_BASE + g)))
        cmp_val[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags <= '0;
    else
      flags <= (flags & ~w1c_mask) | {cmp_evt, ovf_evt};
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADDR_CTRL))
      rd_mux[2:0] = {src_sel, mode};
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(ADDR_CMP_BASE + i))
        rd_mux = cmp_val[i];
    if (addr == ADDR_W'(ADDR_FLAGS))
      rd_mux[NUM_CH:0] = flags;
    if (addr == ADDR_W'(ADDR_COUNT))
      rd_mux = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= rd_mux;
  end

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             moved,
  output logic             rising,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dir_q;   // 0 = counting up, 1 = counting down
  logic dir_n;
  logic adv;

  always_comb begin
    nxt   = cnt;
    dir_n = dir_q;
    case (mode)
      MODE_UP:   nxt = (cnt >= top_val) ? '0 : cnt + ONE;
      MODE_CONT: nxt = cnt + ONE;
      MODE_UPDN: begin
        if (!dir_q) begin
          if (cnt < top_val) begin
            nxt = cnt + ONE;
          end else if (cnt != '0) begin
            // turn around without repeating the peak
            nxt   = cnt - ONE;
            dir_n = 1'b1;
          end
        end else begin
          if (cnt != '0) begin
            nxt = cnt - ONE;
          end else if (top_val != '0) begin
            // turn around without repeating zero
            nxt   = ONE;
            dir_n = 1'b0;
          end
        end
      end
      default: nxt = cnt;
    endcase
  end

  assign adv     = tick && !clr && (mode != MODE_STOP);
  assign moved   = adv && (nxt != cnt);
  assign rising  = nxt > cnt;
  assign ovf_evt = moved && (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      dir_q <= 1'b0;
    end else begin
      if (adv)
        cnt <= nxt;
      if (mode != MODE_UPDN)
        dir_q <= 1'b0;
      else if (adv)
        dir_q <= dir_n;
    end
  end

endmodule

// File: rtl/mmt_channel.sv
module mmt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             gate,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             evt,
  output logic             pin
);

  assign evt = gate && (nxt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst || clr)
      pin <= 1'b0;
    else if (evt)
      pin <= ~pin;
  end

endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] cmp_out
);

  mode_e                         mode_q;
  logic                          src_q;
  logic                          clr_pulse;
  logic                          tick_sel;
  logic [NUM_CH-1:0][CNT_W-1:0]  ccr;
  logic [CNT_W-1:0]              cnt_q;
  logic [CNT_W-1:0]              cnt_nxt;
  logic                          moved;
  logic                          rising;
  logic                          ovf_evt;
  logic                          cmp_gate;
  logic [NUM_CH-1:0]             cmp_evt;
  logic [NUM_CH:0]               flags_q;

  assign tick_sel = src_q ? tick_b : tick_a;
  // up/down mode compares only on upward steps
  assign cmp_gate = moved && ((mode_q != MODE_UPDN) || rising);

  mmt_regs #(
    .CNT_W (CNT_W),
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cnt      (cnt_q),
    .cmp_evt  (cmp_evt),
    .ovf_evt  (ovf_evt),
    .mode     (mode_q),
    .src_sel  (src_q),
    .clr_pulse(clr_pulse),
    .cmp_val  (ccr),
    .flags    (flags_q),
    .rdata    (reg_rdata)
  );

  mmt_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_q),
    .tick   (tick_sel),
    .clr    (clr_pulse),
    .top_val(ccr[0]),
    .cnt    (cnt_q),
    .nxt    (cnt_nxt),
    .moved  (moved),
    .rising (rising),
    .ovf_evt(ovf_evt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mmt_channel #(
      .CNT_W(CNT_W)
    ) u_ch (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_pulse),
      .gate   (cmp_gate),
      .nxt    (cnt_nxt),
      .cmp_val(ccr[g]),
      .evt    (cmp_evt[g]),
      .pin    (cmp_out[g])
    );
  end

endmodule

// File: rtl/mmt_checks.sv
module mmt_checks
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic              tick_sel,
  input logic              clr_pulse,
  input mode_e             mode_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  ccr0,
  input logic [NUM_CH-1:0] cmp_out,
  input logic [NUM_CH-1:0] cmp_evt,
  input logic              ovf_evt,
  input logic [NUM_CH:0]   flags_q
);

  // R8: halted counter keeps its value
  a_r8_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP && !clr_pulse) |=> $stable(cnt_q));

  // R9: clear zeroes count and pins
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> (cnt_q == '0 && cmp_out == '0));

  // R3: a tick at or above the period wraps to zero
  a_r3_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_UP && tick_sel && !clr_pulse && cnt_q >= ccr0) |=> (cnt_q == '0));

  // R5: up/down count stays within 0..P while nothing is written
  a_r5_updown_bounded: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_UPDN && !reg_we && !clr_pulse && cnt_q <= ccr0) |=> (cnt_q <= ccr0));

  // R7: pins move only on a compare event or a clear
  a_r7_pins_quiet: assert property (@(posedge clk) disable iff (rst)
    (!clr_pulse && cmp_evt == '0) |=> $stable(cmp_out));

  // R10: an overflow event always leaves its flag set
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flags_q[0]);

endmodule

bind mm_timer mmt_checks #(
  .CNT_W (CNT_W),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .tick_sel (tick_sel),
  .clr_pulse(clr_pulse),
  .mode_q   (mode_q),
  .cnt_q    (cnt_q),
  .ccr0     (ccr[0]),
  .cmp_out  (cmp_out),
  .cmp_evt  (cmp_evt),
  .ovf_evt  (ovf_evt),
  .flags_q  (flags_q)
);

// File: tb/tb_mm_timer.sv
module tb_mm_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_a = 1'b0;
  logic        tick_b = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  cmp_out;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;

  mm_timer dut (
    .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_out(cmp_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_dir, m_mode, m_src, m_flags, m_rd, m_pins;
  int m_ccr [3];

  always @(posedge clk) begin
    int rd, nx, nd, ev, w1c;
    bit tk, clr;
    if (rst) begin
      m_cnt = 0; m_dir = 0; m_mode = 0; m_src = 0; m_flags = 0;
      m_rd = 0; m_pins = 0;
      for (int i = 0; i < 3; i++) m_ccr[i] = 0;
    end else begin
      rd = 0;
      case (int'(reg_addr))
        0: rd = m_src * 4 + m_mode;
        1, 2, 3: rd = m_ccr[int'(reg_addr) - 1];
        4: rd = m_flags;
        5: rd = m_cnt;
        default: rd = 0;
      endcase
      tk  = (m_src != 0) ? tick_b : tick_a;
      clr = reg_we && reg_addr == 3'd0 && reg_wdata[3];
      ev  = 0;
      if (clr) begin
        m_cnt = 0; m_dir = 0; m_pins = 0;
      end else begin
        if (tk && m_mode != 0) begin
          nx = m_cnt; nd = m_dir;
          if (m_mode == 1) nx = (m_cnt >= m_ccr[0]) ? 0 : m_cnt + 1;
          else if (m_mode == 2) nx = (m_cnt + 1) % 65536;
          else if (m_dir == 0) begin
            if (m_cnt < m_ccr[0]) nx = m_cnt + 1;
            else if (m_cnt != 0) begin nx = m_cnt - 1; nd = 1; end
          end else begin
            if (m_cnt != 0) nx = m_cnt - 1;
            else if (m_ccr[0] != 0) begin nx = 1; nd = 0; end
          end
          if (nx != m_cnt) begin
            if (nx == 0) ev = ev | 1;
            for (int c = 0; c < 3; c++)
              if (nx == m_ccr[c] && (m_mode != 3 || nx > m_cnt)) begin
                ev = ev | (2 << c);
                m_pins = m_pins ^ (1 << c);
              end
          end
          m_cnt = nx; m_dir = nd;
        end
        if (m_mode != 3) m_dir = 0;
      end
      w1c = (reg_we && reg_addr == 3'd4) ? int'(reg_wdata[3:0]) : 0;
      m_flags = (m_flags & ~w1c) | ev;
      if (reg_we) begin
        if (reg_addr == 3'd0) begin
          m_mode = int'(reg_wdata[1:0]);
          m_src  = int'(reg_wdata[2]);
        end else if (reg_addr >= 3'd1 && reg_addr <= 3'd3) begin
          m_ccr[int'(reg_addr) - 1] = int'(reg_wdata);
        end
      end
      m_rd = rd;
    end
    started = 1;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (cmp_out !== 3'(m_pins)) begin
        mismatched++;
        $display("FAIL R7 cmp_out actual %b expected %b", cmp_out, 3'(m_pins));
      end
      compared++;
      if (reg_rdata !== 16'(m_rd)) begin
        mismatched++;
        $display("FAIL R11 R10 reg_rdata actual %h expected %h", reg_rdata, 16'(m_rd));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'(a);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic toggle_gap(input int ch, output int gap);
    logic prev;
    int n;
    prev = cmp_out[ch]; n = 0;
    while (cmp_out[ch] == prev && n < 200) begin @(negedge clk); n++; end
    prev = cmp_out[ch]; n = 0;
    do begin @(negedge clk); n++; end while (cmp_out[ch] == prev && n < 200);
    gap = n;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired (R1 run did not finish) actual hung expected done");
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int v, v2, g;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pins after reset", int'(cmp_out), 0);
    rd(0, v); check("R1 control after reset", v, 0);
    rd(4, v); check("R1 flags after reset", v, 0);
    rd(5, v); check("R1 count after reset", v, 0);

    // R11 register map read-back
    wr(1, 4); wr(2, 2); wr(3, 7);
    rd(2, v); check("R11 channel1 compare read-back", v, 2);
    wr(0, 1);
    rd(0, v); check("R11 control read-back", v, 1);

    // R3 / R7 up mode, period 5
    tick_a = 1'b1;
    toggle_gap(0, g); check("R3 up mode pin0 gap", g, 5);
    toggle_gap(1, g); check("R7 up mode pin1 gap", g, 5);
    check("R7 unreachable compare keeps pin2 low", int'(cmp_out[2]), 0);
    wr(0, 0);
    rd(4, v); check("R3 R7 flags after up run", v, 7);
    wr(4, 15);
    rd(4, v); check("R10 flags cleared by write-one", v, 0);

    // R2 source select
    wr(1, 1000);
    wr(0, 5);             // up mode, tick_b selected
    tick_a = 1'b1; tick_b = 1'b0;
    rd(5, v); repeat (20) @(negedge clk); rd(5, v2);
    check("R2 unselected enable ignored", v2, v);
    tick_b = 1'b1;
    repeat (20) @(negedge clk); rd(5, v2);
    check("R2 selected enable advances", int'(v2 > v), 1);

    // R8 halted mode
    wr(0, 4);
    rd(5, v); repeat (30) @(negedge clk); rd(5, v2);
    check("R8 halted count holds", v2, v);

    // R9 clear with a tick in the same cycle
    wr(0, 5);
    repeat (10) @(negedge clk);
    wr(0, 8 + 4 + 1);
    tick_a = 1'b0; tick_b = 1'b0;
    check("R9 pins cleared", int'(cmp_out), 0);
    rd(5, v); check("R9 count cleared, same-cycle tick ignored", v, 0);
    rd(0, v); check("R9 clear bit reads as zero", v, 5);

    // R5 / R6 up/down, P = 5
    wr(0, 8); wr(4, 15); wr(1, 5); wr(2, 3);
    wr(0, 3);
    tick_a = 1'b1;
    toggle_gap(0, g); check("R5 up/down pin0 gap 2P", g, 10);
    toggle_gap(1, g); check("R6 up/down pin1 upward only", g, 10);
    wr(0, 0);
    rd(4, v); check("R6 flags after up/down run", v, 7);

    // R4 continuous wrap
    wr(0, 8); wr(4, 15);
    wr(0, 2);
    repeat (65545) @(negedge clk);
    wr(0, 0);
    rd(4, v); check("R4 continuous wrap sets overflow", v & 1, 1);
    check("R4 all compares reached in full range", v, 15);

    // random mixed phase, model compared every cycle
    wr(0, 8); wr(4, 15);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick_a = 1'($urandom_range(0, 1));
      tick_b = 1'($urandom_range(0, 1));
      reg_addr = 3'($urandom_range(0, 5));
      reg_we = ($urandom_range(0, 7) == 0);
      case (int'(reg_addr))
        0: reg_wdata = 16'(($urandom_range(0, 15) == 0 ? 8 : 0) | $urandom_range(0, 7));
        1, 2, 3: reg_wdata = 16'($urandom_range(0, 12));
        default: reg_wdata = 16'($urandom_range(0, 15));
      endcase
    end
    @(negedge clk);
    reg_we = 1'b0; tick_a = 1'b0; tick_b = 1'b0;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end

endmodule